// File: doc/BRIEF.md
# Dual-Bank Host Mailbox Interface

This block connects a PC-style host bus to an embedded controller core through byte-wide mailboxes. The host sees an 8-bit data bus with active-low chip select, read and write strobes, and two address lines. Address line 0 picks either the data register or the status register. Address line 1 picks one of two register banks with the same layout. Bank 0 carries keyboard traffic and bank 1 carries power-management traffic. The core has a load port and a pop port for each bank, and it sees each bank's full flags directly.

The host strobes are not related to the core clock. At the rising edge of a host strobe, the block captures chip select, address and write data in flops clocked by that strobe. It then passes the strobe level through a two-flop synchronizer and updates the flags on the synchronized rising edge. When a configuration input is low, address line 1 is ignored and the block behaves as a single-bank device. The host gets an interrupt when the bank-0 output buffer is full. Two auxiliary buffer-full outputs can be enabled separately. The core can write two sideband outputs: an address-line-20 gate and an active-low host reset.

Top module: `dual_mbox_if`

## Requirements
- R1: The data output enable is high only while chip select and read strobe are both low. An access with only one of them low leaves the enable low.
- R2: A host read with address bit 0 low returns the output data register. A read with address bit 0 high returns the status byte: bit 0 output-buffer-full, bit 1 input-buffer-full, bit 3 command flag, all other bits zero.
- R3: When the bank-2 enable is high, address bit 1 high selects bank 1 for reads and writes. Bank 0 flags and data are not touched by such an access.
- R4: When the bank-2 enable is low, address bit 1 is ignored. A write with bit 1 high lands in bank 0, a read with bit 1 high returns bank 0, and bank 1 state is unchanged.
- R5: A core load of a bank stores the byte and sets that bank's output-buffer-full flag. The host interrupt output equals the bank-0 output-buffer-full flag.
- R6: A host read of a data register (address bit 0 low) clears that bank's output-buffer-full flag once the read strobe rises. A status read leaves the flag set.
- R7: A host write stores the byte present at the rising edge of the write strobe and sets the input-buffer-full flag. The command flag takes the value of address bit 0 for that write.
- R8: A core pop of a bank clears that bank's input-buffer-full flag.
- R9: Auxiliary output 1 follows the bank-0 output-buffer-full flag while its enable is high. Auxiliary output 2 follows the bank-1 flag while its enable is high. Each output is low while its enable is low.
- R10: The gate output (control bit 0) and the host reset output (control bit 1) are set by a core control write. After reset both are high.
- R11: A write strobe pulse while chip select is high changes no flag and no data.
- R12: After reset all buffer-full flags, the interrupt and both auxiliary outputs are low, and the data enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_a0 | input | 1 | Register select: 0 data, 1 status/command |
| hst_a1 | input | 1 | Bank select |
| hst_d_i | input | DW | Host write data from the pad |
| hst_d_o | output | DW | Host read data to the pad |
| hst_d_oe | output | 1 | Pad output enable for host data |
| cfg_bank2_en | input | 1 | Enables decoding of bank 1 |
| cfg_aux1_en | input | 1 | Enables auxiliary buffer-full output 1 |
| cfg_aux2_en | input | 1 | Enables auxiliary buffer-full output 2 |
| core_out_load | input | NUM_BANKS | Per-bank load strobe for the output data register |
| core_out_data | input | DW | Byte loaded by the core |
| core_in_pop | input | NUM_BANKS | Per-bank pop of the input data register |
| core_in_data | output | NUM_BANKS*DW | Input data registers, bank b at bits [b*DW +: DW] |
| core_ibf | output | NUM_BANKS | Input-buffer-full flags |
| core_obf | output | NUM_BANKS | Output-buffer-full flags |
| core_cmd | output | NUM_BANKS | Command flags |
| core_ctl_we | input | 1 | Write strobe for the sideband control bits |
| core_ctl_d | input | 2 | Bit 0 gate value, bit 1 host reset value |
| host_obf_irq | output | 1 | Host output-buffer-full interrupt, active high |
| aux_obf1 | output | 1 | Auxiliary buffer-full output 1 |
| aux_obf2 | output | 1 | Auxiliary buffer-full output 2 |
| addr20_gate | output | 1 | Address-line-20 gate |
| host_rst_n | output | 1 | Host reset, active low |

## Verification
The bench goes after the bank-2 enable. With the enable low, a write with address bit 1 high has to land in bank 0, and a read with bit 1 high has to return bank 0. A decoder that ignored the enable would fill bank 1 and return the wrong byte. The bench checks that a status read leaves the interrupt set and a data read clears it. A design that cleared on any read, or at the falling edge, would lose the buffer-full indication. The bench also sends a write pulse with chip select high, switches each auxiliary enable on and off while its buffer is full, and checks the control bits after reset. A swapped status bit or an aux output without its gate fails on the exact byte or level.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Fixed by address line 1: two banks
  localparam int unsigned NUM_BANKS  = 2;

  // Status byte layout, decoded by host software
  localparam int unsigned ST_OBF_BIT = 0;
  localparam int unsigned ST_IBF_BIT = 1;
  localparam int unsigned ST_CD_BIT  = 3;

  typedef struct packed {
    logic cd;   // last host write targeted the command register
    logic ibf;  // input buffer holds an unread host byte
    logic obf;  // output buffer holds a byte not yet read by the host
  } mbox_flags_t;

endpackage

// File: rtl/mbox_strobe_sync.sv
module mbox_strobe_sync #(
  parameter int unsigned CW     = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe_n,
  input  logic [CW-1:0] cap_in,
  output logic [CW-1:0] cap_out,
  output logic          done_evt
);

  // Capture at the strobe's rising edge in the host timing domain
  logic [CW-1:0] cap_q;
  always_ff @(posedge strobe_n) cap_q <= cap_in;
  assign cap_out = cap_q;

  // Synchronizer plus one edge-detect stage, idle level is high
  logic [STAGES:0] sync_q;
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[STAGES-1:0], strobe_n};
  end

  assign done_evt = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_wr_cmd,
  input  logic [DW-1:0] host_wr_data,
  input  logic          host_rd_done,
  input  logic          core_load,
  input  logic [DW-1:0] core_load_data,
  input  logic          core_pop,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] out_q,
  output mbox_flags_t   flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      out_q <= '0;
      flags <= '0;
    end else begin
      if (host_wr) begin
        in_q      <= host_wr_data;
        flags.ibf <= 1'b1;
        flags.cd  <= host_wr_cmd;
      end else if (core_pop) begin
        flags.ibf <= 1'b0;
      end
      if (core_load) begin
        out_q     <= core_load_data;
        flags.obf <= 1'b1;
      end else if (host_rd_done) begin
        flags.obf <= 1'b0;
      end
    end
  end

  // R5
  obf_set_chk: assert property (@(posedge clk) disable iff (rst)
    core_load |=> flags.obf && out_q == $past(core_load_data));

  // R6
  obf_clr_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd_done && !core_load |=> !flags.obf);

  // R7
  ibf_set_chk: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> flags.ibf && flags.cd == $past(host_wr_cmd));

  // R8
  ibf_pop_chk: assert property (@(posedge clk) disable iff (rst)
    core_pop && !host_wr |=> !flags.ibf);

endmodule

// File: rtl/dual_mbox_if.sv
module dual_mbox_if
  import mbox_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hst_cs_n,
  input  logic                    hst_rd_n,
  input  logic                    hst_wr_n,
  input  logic                    hst_a0,
  input  logic                    hst_a1,
  input  logic [DW-1:0]           hst_d_i,
  output logic [DW-1:0]           hst_d_o,
  output logic                    hst_d_oe,
  input  logic                    cfg_bank2_en,
  input  logic                    cfg_aux1_en,
  input  logic                    cfg_aux2_en,
  input  logic [NUM_BANKS-1:0]    core_out_load,
  input  logic [DW-1:0]           core_out_data,
  input  logic [NUM_BANKS-1:0]    core_in_pop,
  output logic [NUM_BANKS*DW-1:0] core_in_data,
  output logic [NUM_BANKS-1:0]    core_ibf,
  output logic [NUM_BANKS-1:0]    core_obf,
  output logic [NUM_BANKS-1:0]    core_cmd,
  input  logic                    core_ctl_we,
  input  logic [1:0]              core_ctl_d,
  output logic                    host_obf_irq,
  output logic                    aux_obf1,
  output logic                    aux_obf2,
  output logic                    addr20_gate,
  output logic                    host_rst_n
);

  localparam int unsigned WCAP_W = DW + 3;
  localparam int unsigned RCAP_W = 3;

  // ---------------- strobe capture and synchronization ----------------
  logic [WCAP_W-1:0] wcap;
  logic [RCAP_W-1:0] rcap;
  logic              wr_evt, rd_evt;

  mbox_strobe_sync #(.CW(WCAP_W), .STAGES(SYNC_STAGES)) i_wr_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (hst_wr_n),
    .cap_in   ({hst_cs_n, hst_a1, hst_a0, hst_d_i}),
    .cap_out  (wcap),
    .done_evt (wr_evt)
  );

  mbox_strobe_sync #(.CW(RCAP_W), .STAGES(SYNC_STAGES)) i_rd_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (hst_rd_n),
    .cap_in   ({hst_cs_n, hst_a1, hst_a0}),
    .cap_out  (rcap),
    .done_evt (rd_evt)
  );

  logic          wr_cs_n, wr_a1, wr_a0;
  logic [DW-1:0] wr_data;
  logic          rd_cs_n, rd_a1, rd_a0;
  assign {wr_cs_n, wr_a1, wr_a0, wr_data} = wcap;
  assign {rd_cs_n, rd_a1, rd_a0}          = rcap;

  // ---------------- bank decode ----------------
  logic                 wr_bank, rd_bank;
  logic [NUM_BANKS-1:0] wr_hit_vec, rd_hit_vec;

  assign wr_bank    = wr_a1 & cfg_bank2_en;
  assign rd_bank    = rd_a1 & cfg_bank2_en;
  assign wr_hit_vec = (wr_evt && !wr_cs_n) ? (NUM_BANKS'(1) << wr_bank) : '0;
  assign rd_hit_vec = (rd_evt && !rd_cs_n && !rd_a0) ? (NUM_BANKS'(1) << rd_bank) : '0;

  // ---------------- banks ----------------
  logic [DW-1:0] out_arr  [NUM_BANKS];
  mbox_flags_t   flag_arr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    mbox_bank #(.DW(DW)) i_bank (
      .clk            (clk),
      .rst            (rst),
      .host_wr        (wr_hit_vec[b]),
      .host_wr_cmd    (wr_a0),
      .host_wr_data   (wr_data),
      .host_rd_done   (rd_hit_vec[b]),
      .core_load      (core_out_load[b]),
      .core_load_data (core_out_data),
      .core_pop       (core_in_pop[b]),
      .in_q           (core_in_data[b*DW +: DW]),
      .out_q          (out_arr[b]),
      .flags          (flag_arr[b])
    );
    assign core_ibf[b] = flag_arr[b].ibf;
    assign core_obf[b] = flag_arr[b].obf;
    assign core_cmd[b] = flag_arr[b].cd;
  end

  // ---------------- host read path ----------------
  logic          live_bank;
  logic [DW-1:0] status_byte;

  assign live_bank = hst_a1 & cfg_bank2_en;

  always_comb begin
    status_byte             = '0;
    status_byte[ST_OBF_BIT] = flag_arr[live_bank].obf;
    status_byte[ST_IBF_BIT] = flag_arr[live_bank].ibf;
    status_byte[ST_CD_BIT]  = flag_arr[live_bank].cd;
  end

  assign hst_d_o  = hst_a0 ? status_byte : out_arr[live_bank];
  assign hst_d_oe = ~hst_cs_n & ~hst_rd_n;

  // ---------------- interrupts and sideband ----------------
  assign host_obf_irq = flag_arr[0].obf;

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_obf1    <= 1'b0;
      aux_obf2    <= 1'b0;
      addr20_gate <= 1'b1;
      host_rst_n  <= 1'b1;
    end else begin
      aux_obf1 <= flag_arr[0].obf & cfg_aux1_en;
      aux_obf2 <= flag_arr[1].obf & cfg_aux2_en;
      if (core_ctl_we) begin
        addr20_gate <= core_ctl_d[0];
        host_rst_n  <= core_ctl_d[1];
      end
    end
  end

  // R4
  bank2_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_bank2_en |=> !$rose(core_ibf[1]));

  // R9
  aux1_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_aux1_en) |-> !aux_obf1);

  // R9
  aux2_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_aux2_en) |-> !aux_obf2);

  // R10
  ctl_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> addr20_gate && host_rst_n);

endmodule

// File: tb/test_dual_mbox_if.sv
module test_dual_mbox_if;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hst_cs_n = 1'b1, hst_rd_n = 1'b1, hst_wr_n = 1'b1, hst_a0 = 1'b0, hst_a1 = 1'b0;
  logic [DW-1:0] hst_d_i = '0;
  logic [DW-1:0] hst_d_o;
  logic hst_d_oe;
  logic cfg_bank2_en = 1'b0, cfg_aux1_en = 1'b0, cfg_aux2_en = 1'b0;
  logic [1:0] core_out_load = '0;
  logic [DW-1:0] core_out_data = '0;
  logic [1:0] core_in_pop = '0;
  logic [2*DW-1:0] core_in_data;
  logic [1:0] core_ibf, core_obf, core_cmd;
  logic core_ctl_we = 1'b0;
  logic [1:0] core_ctl_d = '0;
  logic host_obf_irq, aux_obf1, aux_obf2, addr20_gate, host_rst_n;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mbox_if #(.DW(DW)) i_dual_mbox_if (
    .clk(clk), .rst(rst),
    .hst_cs_n(hst_cs_n), .hst_rd_n(hst_rd_n), .hst_wr_n(hst_wr_n),
    .hst_a0(hst_a0), .hst_a1(hst_a1), .hst_d_i(hst_d_i),
    .hst_d_o(hst_d_o), .hst_d_oe(hst_d_oe),
    .cfg_bank2_en(cfg_bank2_en), .cfg_aux1_en(cfg_aux1_en), .cfg_aux2_en(cfg_aux2_en),
    .core_out_load(core_out_load), .core_out_data(core_out_data),
    .core_in_pop(core_in_pop), .core_in_data(core_in_data),
    .core_ibf(core_ibf), .core_obf(core_obf), .core_cmd(core_cmd),
    .core_ctl_we(core_ctl_we), .core_ctl_d(core_ctl_d),
    .host_obf_irq(host_obf_irq), .aux_obf1(aux_obf1), .aux_obf2(aux_obf2),
    .addr20_gate(addr20_gate), .host_rst_n(host_rst_n)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic cs_n, input logic a1, input logic a0, input logic [DW-1:0] d);
    @(negedge clk);
    hst_cs_n = cs_n; hst_a1 = a1; hst_a0 = a0; hst_d_i = d; hst_wr_n = 1'b0;
    @(negedge clk);
    hst_wr_n = 1'b1;
    @(negedge clk);
    hst_cs_n = 1'b1; hst_d_i = 8'h00;
    idle(5);
  endtask

  task automatic host_rd(input logic a1, input logic a0, output logic [DW-1:0] d, output logic oe);
    @(negedge clk);
    hst_cs_n = 1'b0; hst_a1 = a1; hst_a0 = a0; hst_rd_n = 1'b0;
    @(negedge clk);
    d = hst_d_o; oe = hst_d_oe;
    hst_rd_n = 1'b1;
    @(negedge clk);
    hst_cs_n = 1'b1;
    idle(5);
  endtask

  task automatic core_load(input int b, input logic [DW-1:0] d);
    @(negedge clk);
    core_out_load[b] = 1'b1; core_out_data = d;
    @(negedge clk);
    core_out_load = '0;
    idle(2);
  endtask

  task automatic core_pop(input int b);
    @(negedge clk);
    core_in_pop[b] = 1'b1;
    @(negedge clk);
    core_in_pop = '0;
    idle(1);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d; logic oe;
    chk("R12", "oe idle", {15'd0, hst_d_oe}, 16'd0);
    chk("R12", "irq/aux", {13'd0, host_obf_irq, aux_obf1, aux_obf2}, 16'd0);
    chk("R12", "flags", {10'd0, core_ibf, core_obf, core_cmd}, 16'd0);
    chk("R10", "ctl reset", {14'd0, host_rst_n, addr20_gate}, 16'h0003);
    host_rd(1'b0, 1'b1, d, oe);
    chk("R12", "status bank0", {8'd0, d}, 16'h0000);
  endtask

  task automatic t_ctl;
    @(negedge clk); core_ctl_we = 1'b1; core_ctl_d = 2'b00;
    @(negedge clk); core_ctl_we = 1'b0;
    chk("R10", "ctl cleared", {14'd0, host_rst_n, addr20_gate}, 16'h0000);
    @(negedge clk); core_ctl_we = 1'b1; core_ctl_d = 2'b10;
    @(negedge clk); core_ctl_we = 1'b0;
    chk("R10", "ctl mixed", {14'd0, host_rst_n, addr20_gate}, 16'h0002);
    @(negedge clk); core_ctl_we = 1'b1; core_ctl_d = 2'b11;
    @(negedge clk); core_ctl_we = 1'b0;
  endtask

  task automatic t_write_pop;
    logic [DW-1:0] d; logic oe;
    host_wr(1'b0, 1'b0, 1'b0, 8'h5A);
    chk("R7", "ibf0 after data write", {14'd0, core_ibf}, 16'h0001);
    chk("R7", "in data0", {8'd0, core_in_data[7:0]}, 16'h005A);
    chk("R7", "cmd flag data write", {14'd0, core_cmd}, 16'h0000);
    host_rd(1'b0, 1'b1, d, oe);
    chk("R2", "status ibf", {8'd0, d}, 16'h0002);
    core_pop(0);
    chk("R8", "ibf0 after pop", {14'd0, core_ibf}, 16'h0000);
    host_wr(1'b0, 1'b0, 1'b1, 8'hD1);
    chk("R7", "cmd flag cmd write", {14'd0, core_cmd}, 16'h0001);
    host_rd(1'b0, 1'b1, d, oe);
    chk("R2", "status ibf+cd", {8'd0, d}, 16'h000A);
    core_pop(0);
    host_rd(1'b0, 1'b1, d, oe);
    chk("R8", "status after pop", {8'd0, d}, 16'h0008);
  endtask

  task automatic t_load_read;
    logic [DW-1:0] d; logic oe;
    core_load(0, 8'h33);
    chk("R5", "irq after load", {15'd0, host_obf_irq}, 16'd1);
    host_rd(1'b0, 1'b1, d, oe);
    chk("R2", "status obf+cd", {8'd0, d}, 16'h0009);
    chk("R6", "irq after status read", {15'd0, host_obf_irq}, 16'd1);
    host_rd(1'b0, 1'b0, d, oe);
    chk("R2", "data read", {8'd0, d}, 16'h0033);
    chk("R1", "oe during read", {15'd0, oe}, 16'd1);
    chk("R6", "irq after data read", {15'd0, host_obf_irq}, 16'd0);
  endtask

  task automatic t_oe_and_cs;
    @(negedge clk); hst_cs_n = 1'b0;
    @(negedge clk);
    chk("R1", "oe cs only", {15'd0, hst_d_oe}, 16'd0);
    hst_cs_n = 1'b1; hst_rd_n = 1'b0;
    @(negedge clk);
    chk("R1", "oe rd only", {15'd0, hst_d_oe}, 16'd0);
    hst_rd_n = 1'b1;
    idle(5);
    host_wr(1'b1, 1'b0, 1'b0, 8'hEE);
    chk("R11", "ibf after cs-high write", {14'd0, core_ibf}, 16'h0000);
    chk("R11", "data after cs-high write", {8'd0, core_in_data[7:0]}, 16'h00D1);
  endtask

  task automatic t_bank2;
    logic [DW-1:0] d; logic oe;
    cfg_bank2_en = 1'b1;
    host_wr(1'b0, 1'b1, 1'b0, 8'hA5);
    chk("R3", "ibf bank1 only", {14'd0, core_ibf}, 16'h0002);
    chk("R3", "in data1", {8'd0, core_in_data[15:8]}, 16'h00A5);
    host_rd(1'b1, 1'b1, d, oe);
    chk("R3", "status bank1", {8'd0, d}, 16'h0002);
    host_rd(1'b0, 1'b1, d, oe);
    chk("R3", "status bank0 untouched", {8'd0, d}, 16'h0008);
    core_pop(1);
    core_load(1, 8'h77);
    chk("R3", "obf bank1 only", {14'd0, core_obf}, 16'h0002);
    chk("R5", "irq follows bank0 only", {15'd0, host_obf_irq}, 16'd0);
    chk("R9", "aux2 disabled", {15'd0, aux_obf2}, 16'd0);
    @(negedge clk); cfg_aux2_en = 1'b1;
    idle(2);
    chk("R9", "aux2 enabled", {14'd0, aux_obf1, aux_obf2}, 16'h0001);
    host_rd(1'b1, 1'b0, d, oe);
    chk("R3", "data bank1", {8'd0, d}, 16'h0077);
    chk("R6", "obf bank1 cleared", {14'd0, core_obf}, 16'h0000);
    chk("R9", "aux2 after read", {15'd0, aux_obf2}, 16'd0);
    @(negedge clk); cfg_aux1_en = 1'b1;
    core_load(0, 8'h44);
    chk("R9", "aux1 enabled", {14'd0, host_obf_irq, aux_obf1}, 16'h0003);
    @(negedge clk); cfg_aux1_en = 1'b0;
    idle(2);
    chk("R9", "aux1 disabled, irq kept", {14'd0, host_obf_irq, aux_obf1}, 16'h0002);
    host_rd(1'b0, 1'b0, d, oe);
    chk("R6", "irq cleared bank0", {15'd0, host_obf_irq}, 16'd0);
  endtask

  task automatic t_bank2_off;
    logic [DW-1:0] d; logic oe;
    @(negedge clk); cfg_bank2_en = 1'b0;
    host_wr(1'b0, 1'b1, 1'b0, 8'h3C);
    chk("R4", "ibf goes to bank0", {14'd0, core_ibf}, 16'h0001);
    chk("R4", "in data0", {8'd0, core_in_data[7:0]}, 16'h003C);
    chk("R4", "in data1 kept", {8'd0, core_in_data[15:8]}, 16'h00A5);
    core_load(1, 8'h99);
    host_rd(1'b1, 1'b0, d, oe);
    chk("R4", "read a1 returns bank0", {8'd0, d}, 16'h0044);
    chk("R4", "bank1 obf kept", {14'd0, core_obf}, 16'h0002);
    host_rd(1'b1, 1'b1, d, oe);
    chk("R4", "status a1 shows bank0", {8'd0, d}, 16'h0002);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_ctl();
    t_write_pop();
    t_load_read();
    t_oe_and_cs();
    t_bank2();
    t_bank2_off();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule